// File: doc/BRIEF.md
# Converter Offset Calibration Sequencer

This block runs the offset calibration of a 10-bit sampling converter engine. After a start pulse it places the engine in compensation sensing, with only channel 0 selected. In that mode the converter input is tied to half of the reference, so a perfect converter would return the mid-scale code on every sample. The block waits a programmable settling time. It then collects sixteen channel-0 results, each at least one full sample period after the previous one, so that every result comes from a new conversion.

The sixteen results are summed in a 14-bit accumulator. The sum is shifted right by four to give the average. The block reports mid-scale (512) minus that average as an 11-bit signed correction. Once the last sample is taken, compensation sensing and the channel-0 override are released, and the engine control state goes back to what it was before the run. The correction is held until the next run completes.

Results enter on a valid/ready stream. The engine holds `res_valid_i` and `res_data_i` steady until it sees `res_ready_o` high at a clock edge. The block raises ready only in the sampling window after each wait has expired, and ready never depends on valid. A result is taken only on a cycle where both are high. If the engine drops valid, the block waits and loses nothing.

Top module: `offset_cal_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `res_ready_o`, `cmp_sense_o` and `ch0_force_o` are 0, and `corr_o` is 0.
- R2: A start pulse while idle makes `busy_o` high from the next cycle. `cmp_sense_o` and `ch0_force_o` are high exactly while `busy_o` is high.
- R3: The first `res_ready_o` appears exactly SETTLE_CYC + GAP_CYC cycles after the start is taken.
- R4: After each accepted result, `res_ready_o` stays low for exactly GAP_CYC cycles before it is raised again.
- R5: `res_ready_o` is high only while busy. A result is consumed only when valid and ready are both high, and a low valid stalls the run without loss.
- R6: Exactly 16 results are consumed per run.
- R7: `corr_o` equals 512 minus (sum of the 16 results shifted right by 4), as 11-bit two's complement in the range -511..512.
- R8: `done_o` is a one-cycle pulse in the first cycle that shows the new `corr_o`. `busy_o` is already low in that cycle.
- R9: `corr_o` holds between completions, and a start pulse while busy has no effect on timing or result.
- R10: Each run starts from a cleared accumulator, so earlier runs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a calibration run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a new correction is posted |
| res_valid_i | input | 1 | Engine result valid |
| res_data_i | input | 10 | Engine channel-0 result |
| res_ready_o | output | 1 | Block accepts a result |
| cmp_sense_o | output | 1 | Compensation sensing enable to the engine |
| ch0_force_o | output | 1 | Channel-0-only select to the engine |
| corr_o | output | 11 | Signed offset correction |

## Verification
The bench measures the exact distance from start to the first ready and from a handshake to the next ready. A wrong settle or gap count would shift these by a cycle. It feeds all-zero, all-full-scale and mid-scale inputs, which check the sign and range of the result; a missing sign bit would show +1537 where -511 is expected. It also feeds a sum whose low four bits are non-zero, to catch rounding where truncation is required. A stalled valid stream and a second start during a run are applied. A design that consumed a sample without a handshake, or restarted on the extra start, would give a wrong count or late timing. Runs are chained so that an accumulator that is not cleared would corrupt the next result.

// File: rtl/ocal_pkg.sv
`timescale 1ns/1ps
package ocal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GAP,
    ST_TAKE,
    ST_FINISH
  } ocal_state_e;
endpackage

// File: rtl/ocal_timer.sv
`timescale 1ns/1ps
module ocal_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ocal_accum.sv
`timescale 1ns/1ps
module ocal_accum #(
  parameter int RES_W    = 10,
  parameter int SMP_LOG2 = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    add,
  input  logic [RES_W-1:0]        sample,
  input  logic                    latch,
  output logic signed [RES_W:0]   corr
);
  localparam int ACC_W = RES_W + SMP_LOG2;
  localparam logic [RES_W:0] MID = (RES_W+1)'(1) << (RES_W - 1);

  logic [ACC_W-1:0]      acc_q;
  logic [RES_W-1:0]      avg;
  logic signed [RES_W:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (add)   acc_q <= acc_q + ACC_W'(sample);
  end

  // Average by dropping the low SMP_LOG2 bits (truncation).
  assign avg  = acc_q[ACC_W-1:SMP_LOG2];
  assign diff = $signed(MID - {1'b0, avg});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     corr <= '0;
    else if (latch) corr <= diff;
  end
endmodule

// File: rtl/offset_cal_seq.sv
`timescale 1ns/1ps
module offset_cal_seq
  import ocal_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SMP_LOG2   = 4,
  parameter int SETTLE_CYC = 200000,
  parameter int GAP_CYC    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  output logic                  busy_o,
  output logic                  done_o,
  input  logic                  res_valid_i,
  input  logic [RES_W-1:0]      res_data_i,
  output logic                  res_ready_o,
  output logic                  cmp_sense_o,
  output logic                  ch0_force_o,
  output logic signed [RES_W:0] corr_o
);
  localparam int TMR_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD    = TMR_W'(GAP_CYC - 1);

  ocal_state_e        st_q, st_d;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic               acc_clr, acc_add, acc_latch;
  logic [SMP_LOG2-1:0] smp_cnt_q;
  logic               last_smp;
  logic               done_q;

  assign last_smp = (smp_cnt_q == {SMP_LOG2{1'b1}});

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    acc_clr   = 1'b0;
    acc_add   = 1'b0;
    acc_latch = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d     = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
        acc_clr  = 1'b1;
      end
      ST_SETTLE: if (tmr_zero) begin
        st_d     = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      ST_GAP: if (tmr_zero) st_d = ST_TAKE;
      ST_TAKE: if (res_valid_i) begin
        acc_add = 1'b1;
        if (last_smp) begin
          st_d = ST_FINISH;
        end else begin
          st_d     = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end
      end
      ST_FINISH: begin
        acc_latch = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      smp_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= acc_latch;
      if (acc_clr)      smp_cnt_q <= '0;
      else if (acc_add) smp_cnt_q <= smp_cnt_q + 1'b1;
    end
  end

  ocal_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ocal_accum #(.RES_W(RES_W), .SMP_LOG2(SMP_LOG2)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (acc_clr),
    .add    (acc_add),
    .sample (res_data_i),
    .latch  (acc_latch),
    .corr   (corr_o)
  );

  assign busy_o      = (st_q != ST_IDLE);
  assign cmp_sense_o = busy_o;
  assign ch0_force_o = busy_o;
  assign res_ready_o = (st_q == ST_TAKE);
  assign done_o      = done_q;
endmodule

// File: rtl/ocal_chk.sv
`timescale 1ns/1ps
module ocal_chk #(
  parameter int RES_W    = 10,
  parameter int SMP_LOG2 = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  res_valid_i,
  input logic                  res_ready_o,
  input logic                  cmp_sense_o,
  input logic                  ch0_force_o,
  input logic signed [RES_W:0] corr_o
);
  localparam int NSMP = 1 << SMP_LOG2;
  localparam int MIDV = 1 << (RES_W - 1);

  logic [SMP_LOG2+1:0] hs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hs_n <= '0;
    else if (start_i && !busy_o)       hs_n <= '0;
    else if (res_valid_i && res_ready_o) hs_n <= hs_n + 1'b1;
  end

  // R2
  sense_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_sense_o && ch0_force_o) == busy_o);
  // R5
  ready_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready_o |-> busy_o);
  // R6
  sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(hs_n) == NSMP));
  // R7
  corr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(corr_o) <= MIDV && int'(corr_o) > -MIDV));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R9
  corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(corr_o) || done_o));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i && !res_ready_o) |=> busy_o);
endmodule

bind offset_cal_seq ocal_chk #(.RES_W(RES_W), .SMP_LOG2(SMP_LOG2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .res_valid_i (res_valid_i),
  .res_ready_o (res_ready_o),
  .cmp_sense_o (cmp_sense_o),
  .ch0_force_o (ch0_force_o),
  .corr_o      (corr_o)
);

// File: tb/offset_cal_seq_bench.sv
`timescale 1ns/1ps
module offset_cal_seq_bench;
  localparam int S = 20;
  localparam int G = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, start, busy, done, valid, ready, sense, ch0;
  logic [9:0]        data;
  logic signed [10:0] corr;

  offset_cal_seq #(.RES_W(10), .SMP_LOG2(4), .SETTLE_CYC(S), .GAP_CYC(G)) u_offset_cal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .res_valid_i(valid), .res_data_i(data), .res_ready_o(ready),
    .cmp_sense_o(sense), .ch0_force_o(ch0), .corr_o(corr)
  );

  int vec = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [9:0] pat[16];
  int idx, hs_cnt, t_start, t_first, t_hs, gap_meas, done_cnt, r2_bad;
  bit eng_on = 0, stall = 0, hs_pend = 0, prev_done = 0;
  int expq[$];

  task automatic chk(bit ok, string req, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Engine model (drives stream) and timing observation
  always @(negedge clk) begin
    if (hs_pend) begin
      hs_cnt++;
      idx++;
      t_hs = cyc;
    end
    if (ready && t_first < 0) t_first = cyc;
    if (ready && hs_cnt == 1 && gap_meas < 0) gap_meas = cyc - t_hs;
    if (busy && !(sense && ch0)) r2_bad++;
    if (!busy && (sense || ch0)) r2_bad++;
    if (ready && !busy) r2_bad++;
    valid   = eng_on && !(stall && (cyc % 3 == 0));
    data    = pat[idx[3:0]];
    hs_pend = valid && ready;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      if (expq.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        int e;
        e = expq.pop_front();
        chk(int'(corr) == e, "R7 correction", int'(corr), e);
      end
      chk(!busy, "R8 busy low at done", int'(busy), 0);
    end
    if (done && prev_done) chk(1'b0, "R8 done one cycle", 1, 0);
    prev_done = done;
  end

  task automatic run(string name, bit extra_start);
    int sum;
    logic signed [10:0] held;
    sum = 0;
    for (int i = 0; i < 16; i++) sum += int'(pat[i]);
    expq.push_back(512 - (sum >> 4));
    idx = 0; hs_cnt = 0; t_first = -1; gap_meas = -1; done_cnt = 0; r2_bad = 0;
    eng_on = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_start = cyc;
    chk(busy, "R2 busy after start", int'(busy), 1);
    if (extra_start) begin
      repeat (S / 2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    eng_on = 0;
    $display("run %s done", name);
    chk(t_first - t_start == S + G, "R3 settle", t_first - t_start, S + G);
    chk(gap_meas == G, "R4 gap", gap_meas, G);
    chk(hs_cnt == 16, "R6 count", hs_cnt, 16);
    chk(r2_bad == 0, "R2 R5 control levels", r2_bad, 0);
    held = corr;
    repeat (30) @(negedge clk);
    chk(corr == held && !busy && !ready, "R9 hold", int'(corr), int'(held));
    chk(done_cnt == 1, "R9 single completion", done_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; valid = 1'b0; data = '0;
    for (int i = 0; i < 16; i++) pat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !ready && !sense && !ch0 && corr == 0, "R1 reset", int'(corr), 0);

    for (int i = 0; i < 16; i++) pat[i] = 10'd512;
    run("midscale", 0);                    // R7: 0
    for (int i = 0; i < 16; i++) pat[i] = 10'd1023;
    run("fullscale", 0);                   // R7: -511
    for (int i = 0; i < 16; i++) pat[i] = 10'd0;
    run("zero_R10", 0);                    // R10: 512 after full-scale run
    for (int i = 0; i < 16; i++) pat[i] = 10'(400 + 7 * i);
    run("ramp_extra_start", 1);            // R9: start while busy ignored
    for (int i = 0; i < 16; i++) pat[i] = (i == 0) ? 10'd500 : 10'd501;
    stall = 1;
    run("trunc_stall", 0);                 // R5 stall, R7 truncation
    stall = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule